// File: doc/BRIEF.md
# VCO Sub-band Lock Search Controller

This controller picks the oscillator and sub-band that a frequency synthesizer should run on. The synthesizer has three oscillators with eight sub-bands each. The controller drives the two select fields, waits a programmable settling time after every change, and then reads a 3-bit tuning-voltage indicator from the loop. The indicator either reports lock or says that the control voltage sits at one end of its range.

The search starts from a host-supplied setting. It moves one position at a time through the 24 valid settings, in the direction the indicator asks for. It stops at the first setting that locks. It gives up when it runs off either end of the range, or when the indicator reverses the direction it asked for a step earlier.

When the search ends, the block raises `done` together with either `locked` or `failed`. The final settings stay on the outputs until the next start pulse.

Top module: `vco_band_search`

## Requirements
- R1: After reset, `vco_sel` is 00 (all oscillators off), `band_sel` is 0, and `busy`, `done`, `locked` and `failed` are all low.
- R2: A `start` pulse loads `vco_sel`/`band_sel` from `init_vco`/`init_band`, clears `done`, `locked` and `failed`, and raises `busy` on the next cycle. This also applies when a previous search has ended.
- R3: The indicator is sampled only after a settle interval. After each setting change, the sample is taken at the clock edge `settle_cycles`+1 cycles after the edge that made the change. A search that visits k settings therefore ends k*(`settle_cycles`+1) cycles after the start edge.
- R4: An indicator value from 001 to 110 ends the search at the current setting with `done` and `locked` high and `failed` low. `locked` and `failed` are never high together, and either one implies `done`.
- R5: An indicator of 111 moves one position up. Sub-band 7 of oscillator v is followed by sub-band 0 of oscillator v+1. Oscillator codes are 01, 10 and 11, and sub-band codes run 0 to 7.
- R6: An indicator of 000 moves one position down. Sub-band 0 of oscillator v is followed by sub-band 7 of oscillator v-1.
- R7: An indicator of 111 at oscillator 11, sub-band 7 ends the search with `done` and `failed` high, and the settings unchanged.
- R8: An indicator of 000 at oscillator 01, sub-band 0 ends the search with `done` and `failed` high, and the settings unchanged.
- R9: The search ends with `failed` if the indicator reverses direction: 000 on the first sample after an upward step, or 111 on the first sample after a downward step. The settings are left unchanged.
- R10: A start with `init_vco` = 00 ends at once. On the next cycle `done` and `failed` are high, `busy` is low, and `vco_sel` stays 00.
- R11: While not busy and without a start pulse, the settings and status outputs do not change, whatever the indicator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a search |
| init_vco | input | 2 | Initial oscillator select (01..11, 00 = off) |
| init_band | input | 3 | Initial sub-band select |
| settle_cycles | input | SETTLE_W | Settle interval loaded after every setting change |
| tune_ind | input | 3 | Tuning-voltage indicator from the loop |
| vco_sel | output | 2 | Oscillator select |
| band_sel | output | 3 | Sub-band select |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| locked | output | 1 | Search finished at a locking setting |
| failed | output | 1 | Search finished without lock |

## Verification
Direction reversal is the hardest case to reach, because a real loop reports a consistent voltage trend. The bench models the loop from the select outputs. In some modes that model has a gap: below a chosen setting it always asks for a step up, and from that setting on it always asks for a step down, so no setting ever locks. Entering the gap from below tests reversal after an upward step. A second mode, entered from above, tests reversal after a downward step. The same model also drives the search across both oscillator boundaries and into both ends of the range, and each run's cycle count is compared with the settle arithmetic.

// File: rtl/vco_band_search.sv
module vco_band_search #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          init_vco,
  input  logic [2:0]          init_band,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [2:0]          tune_ind,
  output logic [1:0]          vco_sel,
  output logic [2:0]          band_sel,
  output logic                busy,
  output logic                done,
  output logic                locked,
  output logic                failed
);

  localparam logic [4:0] TOP_SET    = 5'b11_111;
  localparam logic [4:0] BOTTOM_SET = 5'b01_000;

  typedef enum logic [1:0] {DIR_NONE, DIR_UP, DIR_DOWN} dir_t;

  logic [4:0]          setting;
  logic [SETTLE_W-1:0] cnt;
  dir_t                last_dir;

  assign vco_sel  = setting[4:3];
  assign band_sel = setting[2:0];

  wire ind_low  = (tune_ind == 3'b000);
  wire ind_high = (tune_ind == 3'b111);
  wire go_up    = ind_high && (setting != TOP_SET)    && (last_dir != DIR_DOWN);
  wire go_down  = ind_low  && (setting != BOTTOM_SET) && (last_dir != DIR_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting  <= '0;
      cnt      <= '0;
      last_dir <= DIR_NONE;
      busy     <= 1'b0;
      done     <= 1'b0;
      locked   <= 1'b0;
      failed   <= 1'b0;
    end else if (start) begin
      setting  <= {init_vco, init_band};
      cnt      <= settle_cycles;
      last_dir <= DIR_NONE;
      locked   <= 1'b0;
      busy     <= (init_vco != 2'b00);
      done     <= (init_vco == 2'b00);
      failed   <= (init_vco == 2'b00);
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (go_up) begin
        setting  <= setting + 5'd1;
        last_dir <= DIR_UP;
        cnt      <= settle_cycles;
      end else if (go_down) begin
        setting  <= setting - 5'd1;
        last_dir <= DIR_DOWN;
        cnt      <= settle_cycles;
      end else begin
        busy   <= 1'b0;
        done   <= 1'b1;
        locked <= !(ind_low || ind_high);
        failed <= ind_low || ind_high;
      end
    end
  end

  AST_BUSY_VCO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vco_sel != 2'b00)); // R5

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start) && $past(busy) && (setting != $past(setting)))
      |-> ((setting == $past(setting) + 5'd1) || (setting == $past(setting) - 5'd1))); // R6

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt != '0) && !start) |=> $stable(setting) && busy); // R3

  AST_DONE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (locked ^ failed)); // R4

  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || failed) |-> done); // R4

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(setting) && $stable(done) && $stable(locked) && !busy); // R11

endmodule

// File: tb/vco_band_search_bench.sv
`timescale 1ns/1ps
module vco_band_search_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] init_vco = 2'b00;
  logic [2:0] init_band = 3'd0;
  logic [7:0] settle_cycles = 8'd0;
  logic [2:0] tune_ind;
  logic [1:0] vco_sel;
  logic [2:0] band_sel;
  logic       busy, done, locked, failed;

  int checks = 0;
  int fails = 0;
  int mode = 0;
  int tgt = 0;
  logic [2:0] lcode = 3'b010;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vco_band_search #(.SETTLE_W(8)) u_vco_band_search (
    .clk(clk), .rst_n(rst_n), .start(start), .init_vco(init_vco),
    .init_band(init_band), .settle_cycles(settle_cycles), .tune_ind(tune_ind),
    .vco_sel(vco_sel), .band_sel(band_sel), .busy(busy), .done(done),
    .locked(locked), .failed(failed));

  // Loop model: position index 0..23 over (oscillator, sub-band)
  int pos;
  always_comb begin
    pos = (vco_sel == 2'b00) ? -1 : (int'(vco_sel) - 1) * 8 + int'(band_sel);
    case (mode)
      0: tune_ind = (pos < tgt) ? 3'b111 : (pos > tgt) ? 3'b000 : lcode;
      1: tune_ind = (pos < tgt) ? 3'b111 : 3'b000;
      2: tune_ind = 3'b111;
      3: tune_ind = 3'b000;
      default: tune_ind = (pos > tgt) ? 3'b000 : 3'b111;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string req, input logic [1:0] iv, input logic [2:0] ib,
                          input int s, input int md, input int t, input logic [2:0] lc,
                          input int exp_pos, input bit exp_lock, input int exp_cycles);
    int n;
    n = 0;
    @(negedge clk);
    mode = md; tgt = t; lcode = lc;
    init_vco = iv; init_band = ib; settle_cycles = 8'(s); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !locked && !failed, "R2", "status cleared after start",
        {busy, done, locked, failed}, 4'b1000);
    chk({vco_sel, band_sel} == {iv, ib}, "R2", "initial setting loaded",
        {vco_sel, band_sel}, {iv, ib});
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(done, req, "search finished", done, 1);
    chk(pos == exp_pos, req, "final position", pos, exp_pos);
    chk(locked == exp_lock && failed == !exp_lock, req, "lock/fail flags",
        {locked, failed}, {exp_lock, !exp_lock});
    chk(n == exp_cycles, "R3", "cycles from start to done", n, exp_cycles);
  endtask

  task automatic t_reset;
    chk(vco_sel == 2'b00 && band_sel == 3'd0, "R1", "reset setting", {vco_sel, band_sel}, 0);
    chk({busy, done, locked, failed} == 4'b0000, "R1", "reset status",
        {busy, done, locked, failed}, 0);
  endtask

  task automatic t_lock_first;   // R4 R3: locks at start position, code 001
    run_case("R4", 2'b10, 3'd3, 4, 0, 11, 3'b001, 11, 1'b1, 5);
  endtask

  task automatic t_up_wrap;      // R5: 6 -> 10 across oscillator 1 -> 2, code 110
    run_case("R5", 2'b01, 3'd6, 2, 0, 10, 3'b110, 10, 1'b1, 15);
    chk(vco_sel == 2'b10 && band_sel == 3'd2, "R5", "select fields after wrap up",
        {vco_sel, band_sel}, 5'b10_010);
  endtask

  task automatic t_down_wrap;    // R6: 17 -> 13 across oscillator 3 -> 2
    run_case("R6", 2'b11, 3'd1, 0, 0, 13, 3'b011, 13, 1'b1, 5);
    chk(vco_sel == 2'b10 && band_sel == 3'd5, "R6", "select fields after wrap down",
        {vco_sel, band_sel}, 5'b10_101);
  endtask

  task automatic t_full_sweep;   // R5: whole range bottom to top
    run_case("R5", 2'b01, 3'd0, 0, 0, 23, 3'b100, 23, 1'b1, 24);
  endtask

  task automatic t_top_fail;     // R7
    run_case("R7", 2'b11, 3'd5, 1, 2, 0, 3'b010, 23, 1'b0, 6);
    chk(vco_sel == 2'b11 && band_sel == 3'd7, "R7", "stays at top setting",
        {vco_sel, band_sel}, 5'b11_111);
  endtask

  task automatic t_bottom_fail;  // R8
    run_case("R8", 2'b01, 3'd2, 3, 3, 0, 3'b010, 0, 1'b0, 12);
    chk(vco_sel == 2'b01 && band_sel == 3'd0, "R8", "stays at bottom setting",
        {vco_sel, band_sel}, 5'b01_000);
  endtask

  task automatic t_reverse_after_up;   // R9
    run_case("R9", 2'b01, 3'd7, 1, 1, 9, 3'b010, 9, 1'b0, 6);
  endtask

  task automatic t_reverse_after_down; // R9
    run_case("R9", 2'b11, 3'd0, 2, 4, 15, 3'b010, 15, 1'b0, 6);
  endtask

  task automatic t_vco_off;      // R10
    @(negedge clk);
    mode = 0; tgt = 5;
    init_vco = 2'b00; init_band = 3'd4; settle_cycles = 8'd3; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done && failed && !locked && !busy, "R10", "immediate failure status",
        {busy, done, locked, failed}, 4'b0101);
    chk(vco_sel == 2'b00, "R10", "oscillators stay off", vco_sel, 0);
  endtask

  task automatic t_idle_hold;    // R11
    logic [4:0] snap;
    logic [2:0] st;
    snap = {vco_sel, band_sel};
    st = {done, locked, failed};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mode = (i % 2 == 0) ? 3 : 2;
    end
    @(posedge clk);
    @(negedge clk);
    chk({vco_sel, band_sel} == snap, "R11", "setting held while idle", {vco_sel, band_sel}, snap);
    chk({done, locked, failed} == st && !busy, "R11", "status held while idle",
        {done, locked, failed}, st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lock_first();
    t_idle_hold();
    t_up_wrap();
    t_down_wrap();
    t_top_fail();
    t_bottom_fail();
    t_reverse_after_up();
    t_reverse_after_down();
    t_vco_off();
    t_full_sweep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule